// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a 16-bit logical address onto a physical address through a per-process table of sixteen segments. The four most significant address bits name a segment and the low twelve bits give the offset inside it. Each table entry holds a base, a limit, a present flag and separate load and store permissions. An offset that passes the checks is added to the entry's base. An offset that fails them yields a fault code and no address.

The table is loaded through a configuration port. That port accepts writes only while the privileged input is high. A flush input invalidates every entry at once, which lets the operating system clear the table on a context switch and then load the table of the incoming process. A bypass input selects a flat 20-bit calculation that shifts a 16-bit segment value left by four bits and adds the whole logical address. This calculation uses no table entry and performs no check. Each request is answered one clock after it is accepted.

Top module: `seg_xlate`

## Requirements
- R1: With real_mode low, req_addr[15:12] selects the entry and req_addr[11:0] is the offset. An access that passes every check returns phys_addr = base + offset, with fault low and fault_code 0.
- R2: An offset that is strictly greater than the entry's limit faults with fault_code 2. An offset equal to the limit is accepted. On every fault phys_addr is 0.
- R3: An access to an entry whose present flag is 0 faults with fault_code 1. This check takes priority over the limit check and the permission checks.
- R4: When req_write is 1 (a store) and the entry has no store permission, the access faults with fault_code 4. When req_write is 0 (a load) and the entry has no load permission, the access faults with fault_code 3. The limit check takes priority over both permission checks.
- R5: After reset, entry 0 is present with base 0x4000, limit 0x06FF and load permission only. Entry 1 is present with base 0x0000, limit 0x04FF, loads and stores. Entry 2 is present with base 0x3000, limit 0x0FFF, loads and stores. All other entries are absent.
- R6: A cfg_we pulse with priv high writes entry cfg_idx, and the new contents apply to requests in the following cycles. With priv low the write is dropped, and cfg_denied is 1 in the cycle after the attempt. A privileged write leaves cfg_denied at 0.
- R7: A cfg_flush pulse with priv high marks every entry absent. A write issued in the same cycle still takes effect for its own index. With priv low a flush is dropped and flagged on cfg_denied, in the same way as a write.
- R8: A request accepted on a clock edge with req_valid high gives rsp_valid = 1 together with its phys_addr, fault and fault_code after that same edge. rsp_valid is 0 after an edge where req_valid was low, and phys_addr, fault and fault_code keep their previous values.
- R9: With real_mode high, phys_addr = (real_seg * 16 + req_addr) mod 2^20, and fault stays low whatever the table contents and req_write.
- R10: With real_mode low, the sum base + offset wraps modulo 2^16, so phys_addr[19:16] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| priv | input | 1 | Privileged mode; table changes are allowed only while it is high |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 16 | Logical address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| real_mode | input | 1 | Selects the flat shift-and-add calculation |
| real_seg | input | 16 | Segment value used when real_mode is high |
| cfg_we | input | 1 | Entry write strobe |
| cfg_flush | input | 1 | Strobe that invalidates all entries |
| cfg_idx | input | 4 | Entry to write |
| cfg_base | input | 16 | Base value to write |
| cfg_limit | input | 12 | Limit value to write |
| cfg_valid | input | 1 | Present flag to write |
| cfg_rd | input | 1 | Load permission to write |
| cfg_wr | input | 1 | Store permission to write |
| cfg_denied | output | 1 | Pulses one cycle after a non-privileged write or flush attempt |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| phys_addr | output | 20 | Translated address, 0 on a fault |
| fault | output | 1 | The response is a fault |
| fault_code | output | 3 | 0 none, 1 absent, 2 limit, 3 load denied, 4 store denied |

## Verification
A translation that is accepted on a clock edge appears on rsp_valid, phys_addr, fault and fault_code right after that edge. The bench therefore drives each request on a falling edge and samples the response on the next falling edge. A table write or flush changes the table on the edge where it is sampled, and cfg_denied is registered on that same edge. The bench reads cfg_denied on the following falling edge, and the first request that can see the change is the one issued at that falling edge. Idle cycles are checked at the same point, one falling edge after the request strobe drops.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FC_NONE     = 3'd0,
    FC_ABSENT   = 3'd1,
    FC_LIMIT    = 3'd2,
    FC_NO_READ  = 3'd3,
    FC_NO_WRITE = 3'd4
  } fault_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W  = 4,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv,
  input  logic              cfg_we,
  input  logic              cfg_flush,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [OFF_W-1:0]  cfg_limit,
  input  logic              cfg_valid,
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  input  logic [SEG_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic              lk_rd,
  output logic              lk_wr,
  output logic [ADDR_W-1:0] lk_base,
  output logic [OFF_W-1:0]  lk_limit,
  output logic              denied
);

  localparam int NSEG = 1 << SEG_W;

  logic [NSEG-1:0][ADDR_W-1:0] base_q, base_d;
  logic [NSEG-1:0][OFF_W-1:0]  limit_q, limit_d;
  logic [NSEG-1:0]             valid_q, valid_d;
  logic [NSEG-1:0]             rd_q, rd_d;
  logic [NSEG-1:0]             wr_q, wr_d;
  logic                        denied_q, denied_d;
  logic                        write_ok, flush_ok, tbl_en;

  function automatic logic [ADDR_W-1:0] boot_base(input int i);
    case (i)
      0:       boot_base = ADDR_W'(32'h4000);
      2:       boot_base = ADDR_W'(32'h3000);
      default: boot_base = '0;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] boot_limit(input int i);
    case (i)
      0:       boot_limit = OFF_W'(32'h06FF);
      1:       boot_limit = OFF_W'(32'h04FF);
      2:       boot_limit = OFF_W'(32'h0FFF);
      default: boot_limit = '0;
    endcase
  endfunction

  assign write_ok = priv & cfg_we;
  assign flush_ok = priv & cfg_flush;
  assign tbl_en   = write_ok | flush_ok;

  always_comb begin
    base_d   = base_q;
    limit_d  = limit_q;
    valid_d  = valid_q;
    rd_d     = rd_q;
    wr_d     = wr_q;
    if (flush_ok) begin
      valid_d = '0;
    end
    if (write_ok) begin
      base_d[cfg_idx]  = cfg_base;
      limit_d[cfg_idx] = cfg_limit;
      valid_d[cfg_idx] = cfg_valid;
      rd_d[cfg_idx]    = cfg_rd;
      wr_d[cfg_idx]    = cfg_wr;
    end
    denied_d = ~priv & (cfg_we | cfg_flush);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= boot_base(i);
        limit_q[i] <= boot_limit(i);
        valid_q[i] <= (i < 3);
        rd_q[i]    <= (i < 3);
        wr_q[i]    <= (i == 1) || (i == 2);
      end
      denied_q <= 1'b0;
    end else begin
      if (tbl_en) begin
        base_q  <= base_d;
        limit_q <= limit_d;
        valid_q <= valid_d;
        rd_q    <= rd_d;
        wr_q    <= wr_d;
      end
      denied_q <= denied_d;
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_rd    = rd_q[lk_idx];
  assign lk_wr    = wr_q[lk_idx];
  assign lk_base  = base_q[lk_idx];
  assign lk_limit = limit_q[lk_idx];
  assign denied   = denied_q;

  // R6: user-mode attempts leave the whole table untouched
  a_r6_user_cannot_modify: assert property (@(posedge clk) disable iff (!rst_n)
    !priv |=> ($stable(base_q) && $stable(limit_q) && $stable(valid_q)
               && $stable(rd_q) && $stable(wr_q)));

  // R6: a user-mode write attempt is flagged in the next cycle
  a_r6_user_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv && cfg_we) |=> denied);

  // R7: a privileged flush with no write leaves every entry absent
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (priv && cfg_flush && !cfg_we) |=> (valid_q == '0));

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 16,
  parameter int RSEG_W = 16,
  parameter int PHYS_W = 20
) (
  input  logic              real_mode,
  input  logic [RSEG_W-1:0] real_seg,
  input  logic [ADDR_W-1:0] logical,
  input  logic [OFF_W-1:0]  offset,
  input  logic              is_write,
  input  logic              ent_valid,
  input  logic              ent_rd,
  input  logic              ent_wr,
  input  logic [ADDR_W-1:0] ent_base,
  input  logic [OFF_W-1:0]  ent_limit,
  output logic [PHYS_W-1:0] phys,
  output fault_e            code
);

  logic [ADDR_W-1:0] tbl_sum;
  logic [PHYS_W-1:0] flat_sum;

  assign tbl_sum  = ent_base + ADDR_W'(offset);
  assign flat_sum = {real_seg, 4'b0000} + PHYS_W'(logical);

  always_comb begin
    code = FC_NONE;
    phys = '0;
    if (real_mode) begin
      phys = flat_sum;
    end else begin
      if (!ent_valid) begin
        code = FC_ABSENT;
      end else if (offset > ent_limit) begin
        code = FC_LIMIT;
      end else if (is_write && !ent_wr) begin
        code = FC_NO_WRITE;
      end else if (!is_write && !ent_rd) begin
        code = FC_NO_READ;
      end
      if (code == FC_NONE) begin
        phys = PHYS_W'(tbl_sum);
      end
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int OFF_W  = 12,
  parameter int RSEG_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    priv,
  input  logic                    req_valid,
  input  logic [SEG_W+OFF_W-1:0]  req_addr,
  input  logic                    req_write,
  input  logic                    real_mode,
  input  logic [RSEG_W-1:0]       real_seg,
  input  logic                    cfg_we,
  input  logic                    cfg_flush,
  input  logic [SEG_W-1:0]        cfg_idx,
  input  logic [SEG_W+OFF_W-1:0]  cfg_base,
  input  logic [OFF_W-1:0]        cfg_limit,
  input  logic                    cfg_valid,
  input  logic                    cfg_rd,
  input  logic                    cfg_wr,
  output logic                    cfg_denied,
  output logic                    rsp_valid,
  output logic [RSEG_W+3:0]       phys_addr,
  output logic                    fault,
  output logic [2:0]              fault_code
);

  localparam int ADDR_W = SEG_W + OFF_W;
  localparam int PHYS_W = RSEG_W + 4;

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              lk_valid, lk_rd, lk_wr;
  logic [ADDR_W-1:0] lk_base;
  logic [OFF_W-1:0]  lk_limit;
  logic [PHYS_W-1:0] phys_d, phys_q;
  fault_e            code_d;
  logic [2:0]        code_q;
  logic              fault_q, rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  seg_table #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .ADDR_W(ADDR_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .priv     (priv),
    .cfg_we   (cfg_we),
    .cfg_flush(cfg_flush),
    .cfg_idx  (cfg_idx),
    .cfg_base (cfg_base),
    .cfg_limit(cfg_limit),
    .cfg_valid(cfg_valid),
    .cfg_rd   (cfg_rd),
    .cfg_wr   (cfg_wr),
    .lk_idx   (req_addr[ADDR_W-1:OFF_W]),
    .lk_valid (lk_valid),
    .lk_rd    (lk_rd),
    .lk_wr    (lk_wr),
    .lk_base  (lk_base),
    .lk_limit (lk_limit),
    .denied   (cfg_denied)
  );

  seg_check #(
    .OFF_W (OFF_W),
    .ADDR_W(ADDR_W),
    .RSEG_W(RSEG_W),
    .PHYS_W(PHYS_W)
  ) u_check (
    .real_mode(real_mode),
    .real_seg (real_seg),
    .logical  (req_addr),
    .offset   (req_addr[OFF_W-1:0]),
    .is_write (req_write),
    .ent_valid(lk_valid),
    .ent_rd   (lk_rd),
    .ent_wr   (lk_wr),
    .ent_base (lk_base),
    .ent_limit(lk_limit),
    .phys     (phys_d),
    .code     (code_d)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rsp_q   <= 1'b0;
      phys_q  <= '0;
      code_q  <= FC_NONE;
      fault_q <= 1'b0;
    end else begin
      rsp_q <= req_valid;
      if (req_valid) begin
        phys_q  <= phys_d;
        code_q  <= code_d;
        fault_q <= (code_d != FC_NONE);
      end
    end
  end

  assign rsp_valid  = rsp_q;
  assign phys_addr  = phys_q;
  assign fault      = fault_q;
  assign fault_code = code_q;

  // R8: every accepted request is answered on the next cycle
  a_r8_answer_next: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_valid |=> rsp_valid);

  // R8: no response without a request, outputs hold
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n_i)
    !req_valid |=> (!rsp_valid && $stable(phys_addr) && $stable(fault_code)));

  // R2: a faulting response carries no address
  a_r2_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rsp_valid && fault) |-> (phys_addr == '0));

  // R9: the flat calculation never faults
  a_r9_flat_no_fault: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && real_mode) |=> !fault);

  // R10: table results stay inside the 16-bit space
  a_r10_table_wraps: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && !real_mode) |=> (phys_addr[PHYS_W-1:ADDR_W] == '0));

endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        priv;
  logic        req_valid;
  logic [15:0] req_addr;
  logic        req_write;
  logic        real_mode;
  logic [15:0] real_seg;
  logic        cfg_we;
  logic        cfg_flush;
  logic [3:0]  cfg_idx;
  logic [15:0] cfg_base;
  logic [11:0] cfg_limit;
  logic        cfg_valid;
  logic        cfg_rd;
  logic        cfg_wr;
  logic        cfg_denied;
  logic        rsp_valid;
  logic [19:0] phys_addr;
  logic        fault;
  logic [2:0]  fault_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] m_base [16];
  logic [11:0] m_lim  [16];
  logic        m_v    [16];
  logic        m_r    [16];
  logic        m_w    [16];

  seg_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .priv(priv),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .real_mode(real_mode), .real_seg(real_seg),
    .cfg_we(cfg_we), .cfg_flush(cfg_flush), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_denied(cfg_denied),
    .rsp_valid(rsp_valid), .phys_addr(phys_addr), .fault(fault),
    .fault_code(fault_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] a, input logic w,
                                output logic [19:0] ep, output logic [2:0] ec);
    logic [3:0]  s;
    logic [11:0] o;
    logic [15:0] sum;
    s = a[15:12];
    o = a[11:0];
    if (!m_v[s])              ec = 3'd1;
    else if (o > m_lim[s])    ec = 3'd2;
    else if (w && !m_w[s])    ec = 3'd4;
    else if (!w && !m_r[s])   ec = 3'd3;
    else                      ec = 3'd0;
    sum = m_base[s] + {4'h0, o};
    ep  = (ec == 3'd0) ? {4'h0, sum} : 20'h0;
  endfunction

  // starts and ends on a falling edge; result registered on the edge between
  task automatic issue(input logic [15:0] a, input logic w, input logic rm,
                       input logic [15:0] rs);
    req_valid = 1'b1;
    req_addr  = a;
    req_write = w;
    real_mode = rm;
    real_seg  = rs;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic xlate(input logic [15:0] a, input logic w, input string tag);
    logic [19:0] ep;
    logic [2:0]  ec;
    string       t;
    model(a, w, ep, ec);
    if (tag != "") t = tag;
    else if (ec == 3'd0) t = "R1";
    else if (ec == 3'd1) t = "R3";
    else if (ec == 3'd2) t = "R2";
    else t = "R4";
    issue(a, w, 1'b0, 16'h0);
    chk(rsp_valid == 1'b1, {t, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk(fault_code == ec, {t, " fault_code"}, 32'(fault_code), 32'(ec));
    chk(fault == (ec != 3'd0), {t, " fault"}, 32'(fault), 32'(ec != 3'd0));
    chk(phys_addr == ep, {t, " phys_addr"}, 32'(phys_addr), 32'(ep));
  endtask

  task automatic flat(input logic [15:0] rs, input logic [15:0] a, input logic w);
    logic [19:0] ep;
    ep = {rs, 4'h0} + {4'h0, a};
    issue(a, w, 1'b1, rs);
    chk(phys_addr == ep && rsp_valid, "R9 flat phys_addr", 32'(phys_addr), 32'(ep));
    chk(fault == 1'b0 && fault_code == 3'd0, "R9 no fault", 32'(fault_code), 32'd0);
  endtask

  task automatic cfg(input logic p, input logic we, input logic fl, input int idx,
                     input logic [15:0] b, input logic [11:0] l, input logic v,
                     input logic r, input logic w, input string tag);
    logic expd;
    priv      = p;
    cfg_we    = we;
    cfg_flush = fl;
    cfg_idx   = 4'(idx);
    cfg_base  = b;
    cfg_limit = l;
    cfg_valid = v;
    cfg_rd    = r;
    cfg_wr    = w;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_flush = 1'b0;
    priv      = 1'b0;
    if (p) begin
      if (fl) for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
      if (we) begin
        m_base[idx] = b; m_lim[idx] = l; m_v[idx] = v; m_r[idx] = r; m_w[idx] = w;
      end
    end
    expd = !p && (we || fl);
    chk(cfg_denied == expd, {tag, " cfg_denied"}, 32'(cfg_denied), 32'(expd));
  endtask

  task automatic sweep(input int step);
    for (int s = 0; s < 16; s++) begin
      for (int o = 0; o < 4096; o += step) begin
        xlate({4'(s), 12'(o)}, 1'b0, "");
        xlate({4'(s), 12'(o)}, 1'b1, "");
      end
      xlate({4'(s), m_lim[s]}, 1'b0, "");
      if (m_lim[s] != 12'hFFF) xlate({4'(s), m_lim[s] + 12'd1}, 1'b1, "");
      xlate({4'(s), 12'hFFF}, 1'b0, "");
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 200000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] held;
    rst_n = 1'b0; priv = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    real_mode = 1'b0; real_seg = '0; cfg_we = 1'b0; cfg_flush = 1'b0; cfg_idx = '0;
    cfg_base = '0; cfg_limit = '0; cfg_valid = 1'b0; cfg_rd = 1'b0; cfg_wr = 1'b0;
    for (int i = 0; i < 16; i++) begin
      m_base[i] = 16'h0; m_lim[i] = 12'h0; m_v[i] = 1'b0; m_r[i] = 1'b0; m_w[i] = 1'b0;
    end
    m_base[0] = 16'h4000; m_lim[0] = 12'h6FF; m_v[0] = 1; m_r[0] = 1; m_w[0] = 0;
    m_base[1] = 16'h0000; m_lim[1] = 12'h4FF; m_v[1] = 1; m_r[1] = 1; m_w[1] = 1;
    m_base[2] = 16'h3000; m_lim[2] = 12'hFFF; m_v[2] = 1; m_r[2] = 1; m_w[2] = 1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R8 idle outputs)
    chk(rsp_valid == 0, "R8 reset rsp_valid", 32'(rsp_valid), 0);
    chk(fault == 0 && fault_code == 0, "R8 reset fault", 32'(fault_code), 0);
    chk(cfg_denied == 0, "R6 reset cfg_denied", 32'(cfg_denied), 0);

    // R5 boot table, worked addresses
    xlate(16'h0240, 1'b0, "R5");
    xlate(16'h1108, 1'b1, "R5");
    xlate(16'h265C, 1'b0, "R5");
    xlate(16'h3002, 1'b0, "R5");
    xlate(16'h0240, 1'b1, "R4");
    xlate(16'h06FF, 1'b0, "R2");
    xlate(16'h0700, 1'b1, "R2");
    xlate(16'h1500, 1'b0, "R2");

    // R8 outputs hold while idle
    held = phys_addr;
    @(negedge clk);
    chk(rsp_valid == 0, "R8 idle rsp_valid", 32'(rsp_valid), 0);
    chk(phys_addr == held, "R8 idle hold", 32'(phys_addr), 32'(held));

    sweep(7);

    // R6 user write dropped and flagged
    cfg(1'b0, 1'b1, 1'b0, 3, 16'h8000, 12'hFFF, 1'b1, 1'b1, 1'b1, "R6");
    xlate(16'h3002, 1'b0, "R6");
    xlate(16'h0240, 1'b0, "R6");

    // R6 privileged reprogramming of every entry
    for (int i = 0; i < 16; i++) begin
      cfg(1'b1, 1'b1, 1'b0, i, 16'(i * 16'h1357 + 16'hF000), 12'(i * 12'h111),
          (i != 15), (i % 4) != 1, (i % 4) != 2, "R6");
    end
    cfg(1'b1, 1'b1, 1'b0, 5, 16'hFF00, 12'hFFF, 1'b1, 1'b1, 1'b1, "R10");
    xlate(16'h5200, 1'b0, "R10");
    xlate(16'h5FFF, 1'b1, "R10");
    xlate(16'hF000, 1'b0, "R3");
    sweep(7);

    // R7 user flush dropped, privileged flush with a same-cycle write
    cfg(1'b0, 1'b0, 1'b1, 0, 16'h0, 12'h0, 1'b0, 1'b0, 1'b0, "R7");
    xlate(16'h5200, 1'b0, "R7");
    cfg(1'b1, 1'b1, 1'b1, 7, 16'h2468, 12'h100, 1'b1, 1'b1, 1'b0, "R7");
    xlate(16'h7100, 1'b0, "R7");
    xlate(16'h7101, 1'b0, "R7");
    xlate(16'h7000, 1'b1, "R7");
    xlate(16'h5200, 1'b0, "R7");
    sweep(97);

    // R9 flat calculation over absent entries
    flat(16'hF000, 16'hFFF0, 1'b0);
    flat(16'hFFFF, 16'hFFFF, 1'b1);
    for (int s = 0; s < 65536; s += 7919) begin
      for (int a = 0; a < 65536; a += 4099) begin
        flat(16'(s), 16'(a), 1'(a & 1));
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule